// File: doc/BRIEF.md
# Speaker Gate and Bus Error Status Port

This block is a single byte-wide I/O port for a PC-compatible system controller. Software uses it to start timer channel 2 and to let that channel's output reach the speaker pin. The same port also reports three things that software cannot write: a sticky flag for a bus I/O-check error, a bit that flips on every memory refresh, and the live level of the timer channel 2 output.

The I/O-check and refresh inputs come from outside the clock domain. Each passes through a two-flop synchronizer before any logic uses it. An I/O-check error sets a sticky flag, and that flag can raise an NMI request when the NMI enable input is high. Software clears the flag by writing a mask bit. While the mask bit is set, the flag is held clear and no new error is recorded. All outputs are registered. A read returns its data in the clock after the read strobe.

Top module: `spkr_stat_port`

## Requirements
- R1: After reset, tmr2_gate, spkr_out and nmi_req are 0. A read of the port with tmr2_out low returns 0x00.
- R2: A write to the port address stores wdata[3:0], and a later read returns them in bits 3..0. This includes the spare bit 2, which only stores a value.
- R3: Read bit 7 is always 0. Writes to bits 7..4 have no effect on any readback or output.
- R4: tmr2_gate equals stored bit 0 from the clock edge that accepts the write onward.
- R5: spkr_out is tmr2_out delayed by one clock and ANDed with stored bit 1. It is 0 whenever bit 1 is 0.
- R6: Read bit 5 is the tmr2_out level sampled at the clock edge that captures the read. No synchronizer sits in this path.
- R7: The active-low chk_n_in input, once synchronized, sets the error flag. The flag shows in read bit 6 and stays set after chk_n_in goes high again.
- R8: While stored bit 3 is 1, the error flag is cleared and held at 0, even if chk_n_in is low. When bit 3 returns to 0, a chk_n_in input that is still low sets the flag again.
- R9: nmi_req is the error flag ANDed with nmi_en, registered one clock later.
- R10: Read bit 4 toggles on each synchronized rising edge of rfsh_n_in. Falling edges and steady levels leave it unchanged.
- R11: Reads of any other address return 0x00. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | I/O address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the clock after bus_rd |
| chk_n_in | input | 1 | Asynchronous active-low bus I/O-check error |
| rfsh_n_in | input | 1 | Asynchronous active-low refresh indication |
| tmr2_out | input | 1 | Timer channel 2 output |
| nmi_en | input | 1 | NMI enable |
| tmr2_gate | output | 1 | Timer channel 2 gate |
| spkr_out | output | 1 | Speaker drive |
| nmi_req | output | 1 | NMI request |

## Verification
The case that is hardest to reach from the ports is an error input that stays low across a clear. The flag is set by the error level, not by an edge. If the mask bit is lowered while chk_n_in is still low, the flag must set again. The bench holds chk_n_in low, writes the mask bit and checks that bit 6 reads 0. It then clears the mask with the input still low and checks that bit 6 sets again. Every write value from 0 to 255 is also swept, with both timer output levels, to cover the store, ignore and speaker paths.

// File: rtl/spkr_stat_pkg.sv
package spkr_stat_pkg;
  // Bit positions in the port byte (software decodes these)
  localparam int unsigned B_TGATE = 0;
  localparam int unsigned B_SPKEN = 1;
  localparam int unsigned B_SPARE = 2;
  localparam int unsigned B_MASK  = 3;
  localparam int unsigned B_RFTOG = 4;
  localparam int unsigned B_TMR2  = 5;
  localparam int unsigned B_ERR   = 6;
  localparam int unsigned CTRL_W  = 4;

  typedef struct packed {
    logic mask;
    logic spare;
    logic spk_en;
    logic t_gate;
  } ctrl_t;
endpackage

// File: rtl/spkr_sync.sv
module spkr_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [STAGES-1:0] chain [W];

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) chain[b] <= {STAGES{RST_VAL}};
      else     chain[b] <= {chain[b][STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[b][STAGES-1];
  end
endmodule

// File: rtl/spkr_rfsh_tog.sv
module spkr_rfsh_tog (
  input  logic clk,
  input  logic rst,
  input  logic lvl_n,
  output logic tog
);
  logic prev_n;
  logic rise;

  assign rise = lvl_n & ~prev_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_n <= 1'b1;
      tog    <= 1'b0;
    end else begin
      prev_n <= lvl_n;
      if (rise) tog <= ~tog;
    end
  end

  p_flip_r10: assert property (@(posedge clk) disable iff (rst)
    rise |=> (tog != $past(tog)));
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(tog));
endmodule

// File: rtl/spkr_err_latch.sv
module spkr_err_latch (
  input  logic clk,
  input  logic rst,
  input  logic err_act,
  input  logic mask,
  input  logic nmi_en,
  output logic flag,
  output logic nmi_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag    <= 1'b0;
      nmi_req <= 1'b0;
    end else begin
      if (mask)         flag <= 1'b0;
      else if (err_act) flag <= 1'b1;
      nmi_req <= flag & nmi_en;
    end
  end

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (flag && !mask) |=> flag);
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    mask |=> !flag);
  p_nmi_off_r9: assert property (@(posedge clk) disable iff (rst)
    !nmi_en |=> !nmi_req);
endmodule

// File: rtl/spkr_stat_port.sv
module spkr_stat_port
  import spkr_stat_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter logic [15:0] PORT_ADDR   = 16'h0061,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              chk_n_in,
  input  logic              rfsh_n_in,
  input  logic              tmr2_out,
  input  logic              nmi_en,
  output logic              tmr2_gate,
  output logic              spkr_out,
  output logic              nmi_req
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PORT_ADDR);

  ctrl_t       ctrl;
  logic        hit;
  logic [1:0]  sync_q;
  logic        err_flag;
  logic        rf_tog;
  logic [7:0]  rd_val;

  assign hit = (bus_addr == MY_ADDR);

  spkr_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst),
    .d_async({rfsh_n_in, chk_n_in}),
    .q_sync(sync_q)
  );

  spkr_err_latch u_err (
    .clk(clk), .rst(rst),
    .err_act(~sync_q[0]),
    .mask(ctrl.mask),
    .nmi_en(nmi_en),
    .flag(err_flag),
    .nmi_req(nmi_req)
  );

  spkr_rfsh_tog u_rf (
    .clk(clk), .rst(rst),
    .lvl_n(sync_q[1]),
    .tog(rf_tog)
  );

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (bus_wr && hit) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  always_comb begin
    rd_val                   = '0;
    rd_val[CTRL_W-1:0]       = ctrl;
    rd_val[B_RFTOG]          = rf_tog;
    rd_val[B_TMR2]           = tmr2_out;
    rd_val[B_ERR]            = err_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      spkr_out  <= 1'b0;
    end else begin
      bus_rdata <= (bus_rd && hit) ? rd_val : 8'h00;
      spkr_out  <= ctrl.spk_en & tmr2_out;
    end
  end

  assign tmr2_gate = ctrl.t_gate;

  p_bit7_r3: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[7] == 1'b0);
  p_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit) |=> (tmr2_gate == $past(bus_wdata[B_TGATE])));
  p_spk_off_r5: assert property (@(posedge clk) disable iff (rst)
    !ctrl.spk_en |=> !spkr_out);
  p_miss_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !hit) |=> (bus_rdata == 8'h00));
endmodule

// File: tb/tb_spkr_stat_port.sv
module tb_spkr_stat_port;
  localparam int CLK_T = 10;
  localparam logic [15:0] PA = 16'h0061;

  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic chk_n_in = 1'b1, rfsh_n_in = 1'b1, tmr2_out = 1'b0, nmi_en = 1'b0;
  logic tmr2_gate, spkr_out, nmi_req;
  int checks = 0, errors = 0;
  bit tog_exp = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  spkr_stat_port dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_T * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle(4); rst = 1'b0; idle(1);
    // R1 reset state
    chk("R1 gate", {7'b0, tmr2_gate}, 8'h00);
    chk("R1 spkr", {7'b0, spkr_out}, 8'h00);
    chk("R1 nmi", {7'b0, nmi_req}, 8'h00);
    rd(PA, v); chk("R1 read", v, 8'h00);

    // R2 R3 R4 R5 R6 sweep of every write value and both timer levels
    for (int d = 0; d < 256; d++) begin
      wr(PA, 8'(d));
      chk("R4 gate", {7'b0, tmr2_gate}, {7'b0, 1'(d)});
      for (int t = 0; t < 2; t++) begin
        tmr2_out = 1'(t);
        @(negedge clk);
        chk("R5 spkr", {7'b0, spkr_out}, {7'b0, 1'((d >> 1) & t)});
        rd(PA, v);
        chk("R2 R3 R6 read", v, {2'b00, 1'(t), 1'b0, 4'(d)});
      end
    end
    tmr2_out = 1'b0;

    // R11 other address
    wr(PA, 8'h05);
    wr(16'h0060, 8'hFF);
    rd(16'h0060, v); chk("R11 miss read", v, 8'h00);
    rd(PA, v); chk("R11 no write", v, 8'h05);
    wr(PA, 8'h00);

    // R7 R9 error flag and NMI
    nmi_en = 1'b1;
    @(negedge clk); chk_n_in = 1'b0; idle(3); chk_n_in = 1'b1; idle(3);
    rd(PA, v); chk("R7 sticky", v, 8'h40);
    chk("R9 nmi on", {7'b0, nmi_req}, 8'h01);
    nmi_en = 1'b0; idle(2);
    chk("R9 nmi off", {7'b0, nmi_req}, 8'h00);
    nmi_en = 1'b1;

    // R8 clear via mask, blocked while mask set
    wr(PA, 8'h08); idle(1);
    rd(PA, v); chk("R8 cleared", v, 8'h08);
    chk_n_in = 1'b0; idle(4);
    rd(PA, v); chk("R8 blocked", v, 8'h08);
    chk("R9 nmi masked", {7'b0, nmi_req}, 8'h00);
    // mask released while error still low: flag sets again
    wr(PA, 8'h00); idle(2);
    rd(PA, v); chk("R8 relatch", v, 8'h40);
    chk_n_in = 1'b1; wr(PA, 8'h08); wr(PA, 8'h00); idle(4);
    rd(PA, v); chk("R8 stays clear", v, 8'h00);
    nmi_en = 1'b0;

    // R10 refresh toggle
    for (int i = 0; i < 5; i++) begin
      rfsh_n_in = 1'b0; idle(4);
      rd(PA, v); chk("R10 falling no effect", v, {3'b000, tog_exp, 4'h0});
      rfsh_n_in = 1'b1; tog_exp = ~tog_exp; idle(4);
      rd(PA, v); chk("R10 toggle", v, {3'b000, tog_exp, 4'h0});
    end

    // R1 reset again clears everything
    wr(PA, 8'h0F); tmr2_out = 1'b1;
    @(negedge clk); rst = 1'b1; idle(2); rst = 1'b0; tmr2_out = 1'b0; idle(1);
    rd(PA, v); chk("R1 reset clears", v, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule